// File: doc/BRIEF.md
# Set/Clear/Read Aliased Control Register Bank

This block is a small bank of control registers on a simple word-addressed bus. Each register has three word addresses next to each other. A write to the first address turns on the bits that are 1 in the write data. A write to the second address turns those bits off. The third address returns the stored value. Software can therefore change single control bits in one bus write, with no read-modify-write sequence. A zero bit in the write data never changes anything.

The registers drive their contents straight out as one flat parallel control vector. Read data is registered and appears in the cycle after the read request. Addresses below the window base, or past the last register's third address, are not decoded.

Top module: `setclr_reg_bank`

## Requirements
- R1: A synchronous active-high reset clears every register and the read data output to zero.
- R2: Register k uses three word addresses: set at BASE_ADDR+3k, clear at BASE_ADDR+3k+1, and read at BASE_ADDR+3k+2. BASE_ADDR is the lowest address of the window.
- R3: A write to a register's set address makes every bit that is 1 in the write data equal to 1. All other bits keep their values.
- R4: A write to a register's clear address makes every bit that is 1 in the write data equal to 0. All other bits keep their values.
- R5: A write to a read address changes no register.
- R6: A read request to a read address returns the stored value on the read data output one cycle later. A write sampled at one clock edge is seen by a read request presented in the following cycle.
- R7: A read request to a set or clear address returns zero.
- R8: For an address outside the window, a write changes no register and a read returns zero.
- R9: In the cycle after a clock edge with no read request, the read data output is zero.
- R10: The control output carries register k on bits [k*DATA_W +: DATA_W]. It changes on the same clock edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request, sampled on the rising edge |
| bus_rd | input | 1 | Read request, sampled on the rising edge |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data (bit mask for set and clear) |
| bus_rdata | output | DATA_W | Registered read data |
| ctrl_q | output | NUM_REGS*DATA_W | All register contents, register 0 in the low bits |

## Verification
The bench builds the bank with four 16-bit registers, a 6-bit address and a base of 8. This gives a window from address 8 to address 19. Free addresses lie both below the base (0 to 7) and above the window (20 to 63), so random traffic reaches both kinds of out-of-window access.

The window is not aligned to a power of two, and the register count does not fill it to one. The divide-by-three decode is therefore tested at every alias boundary. The highest register sits in bits 63:48 of the control output. This shows whether the output slices are ordered correctly.

// File: rtl/setclr_pkg.sv
package setclr_pkg;
  typedef enum logic [1:0] {
    ALIAS_SET  = 2'd0,
    ALIAS_CLR  = 2'd1,
    ALIAS_READ = 2'd2,
    ALIAS_NONE = 2'd3
  } alias_e;
endpackage

// File: rtl/setclr_decode.sv
module setclr_decode
  import setclr_pkg::*;
#(
  parameter int NUM_REGS  = 4,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 16,
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output alias_e            kind
);
  localparam int SPAN = 3 * NUM_REGS;
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] SPAN_V = ADDR_W'(SPAN);
  localparam logic [ADDR_W-1:0] THREE  = ADDR_W'(3);

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] slot;
  logic [ADDR_W-1:0] sub;

  always_comb begin
    offset = addr - BASE_V;
    slot   = offset / THREE;
    sub    = offset % THREE;
    hit    = (addr >= BASE_V) && (offset < SPAN_V);
    idx    = hit ? IDX_W'(slot) : '0;
    kind   = hit ? alias_e'(sub[1:0]) : ALIAS_NONE;
  end
endmodule

// File: rtl/setclr_cell.sv
module setclr_cell #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_stb,
  input  logic              clr_stb,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (set_stb) begin
      q <= q | mask;
    end else if (clr_stb) begin
      q <= q & ~mask;
    end
  end
endmodule

// File: rtl/setclr_readback.sv
module setclr_readback #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] regs [NUM_REGS],
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (idx == IDX_W'(k)) pick = regs[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= rd_stb ? pick : '0;
    end
  end
endmodule

// File: rtl/setclr_reg_bank.sv
module setclr_reg_bank
  import setclr_pkg::*;
#(
  parameter int NUM_REGS  = 4,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  output logic [NUM_REGS*DATA_W-1:0]   ctrl_q
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic             dec_hit;
  logic [IDX_W-1:0] dec_idx;
  alias_e           dec_kind;
  logic [DATA_W-1:0] reg_q [NUM_REGS];

  setclr_decode #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .addr(bus_addr),
    .hit (dec_hit),
    .idx (dec_idx),
    .kind(dec_kind)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic sel;
    assign sel = dec_hit && (dec_idx == IDX_W'(k));

    setclr_cell #(.DATA_W(DATA_W)) u_cell (
      .clk    (clk),
      .rst    (rst),
      .set_stb(bus_wr && sel && (dec_kind == ALIAS_SET)),
      .clr_stb(bus_wr && sel && (dec_kind == ALIAS_CLR)),
      .mask   (bus_wdata),
      .q      (reg_q[k])
    );

    assign ctrl_q[k*DATA_W +: DATA_W] = reg_q[k];
  end

  setclr_readback #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W)
  ) u_readback (
    .clk   (clk),
    .rst   (rst),
    .rd_stb(bus_rd && (dec_kind == ALIAS_READ)),
    .idx   (dec_idx),
    .regs  (reg_q),
    .rdata (bus_rdata)
  );
endmodule

// File: rtl/setclr_checks.sv
module setclr_checks #(
  parameter int NUM_REGS  = 4,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bus_wr,
  input logic                       bus_rd,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic [NUM_REGS*DATA_W-1:0] ctrl_q
);
  localparam int SPAN = 3 * NUM_REGS;

  logic outside;
  assign outside = (int'(bus_addr) < BASE_ADDR) || (int'(bus_addr) >= BASE_ADDR + SPAN);

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctrl_q == '0 && bus_rdata == '0));

  assert_outside_write_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && outside) |=> $stable(ctrl_q));

  assert_outside_read_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && outside) |=> (bus_rdata == '0));

  assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_chk
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(BASE_ADDR + 3*k);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(BASE_ADDR + 3*k + 1);
    localparam logic [ADDR_W-1:0] RD_A  = ADDR_W'(BASE_ADDR + 3*k + 2);

    assert_set_bits_R3: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == SET_A) |=>
        (ctrl_q[k*DATA_W +: DATA_W] == ($past(ctrl_q[k*DATA_W +: DATA_W]) | $past(bus_wdata))));

    assert_clear_bits_R4: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == CLR_A) |=>
        (ctrl_q[k*DATA_W +: DATA_W] == ($past(ctrl_q[k*DATA_W +: DATA_W]) & ~$past(bus_wdata))));

    assert_read_alias_write_R5: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == RD_A) |=> $stable(ctrl_q));

    assert_read_value_R6: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && bus_addr == RD_A) |=> (bus_rdata == $past(ctrl_q[k*DATA_W +: DATA_W])));

    assert_alias_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && (bus_addr == SET_A || bus_addr == CLR_A)) |=> (bus_rdata == '0));
  end
endmodule

bind setclr_reg_bank setclr_checks #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .BASE_ADDR(BASE_ADDR)
) u_checks (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .ctrl_q   (ctrl_q)
);

// File: tb/tb_setclr_reg_bank.sv
`timescale 1ns/1ps
module tb_setclr_reg_bank;
  localparam int NR = 4;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int BA = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NR*DW-1:0] ctrl_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] model [NR];
  logic [DW-1:0] exp_rd;

  always #2.5 clk = ~clk;

  setclr_reg_bank #(
    .NUM_REGS(NR), .DATA_W(DW), .ADDR_W(AW), .BASE_ADDR(BA)
  ) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ctrl_q(ctrl_q)
  );

  // 0 set, 1 clear, 2 read, 3 outside window
  function automatic int kind_of(int a);
    if (a < BA || a >= BA + 3*NR) return 3;
    return (a - BA) % 3;
  endfunction

  function automatic int reg_of(int a);
    return (a - BA) / 3;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all(string wtag, string rtag);
    logic [NR*DW-1:0] flat;
    for (int k = 0; k < NR; k++) flat[k*DW +: DW] = model[k];
    check(wtag, 64'(ctrl_q), 64'(flat));
    check(rtag, 64'(bus_rdata), 64'(exp_rd));
  endtask

  task automatic step(bit wr, bit rd, int a, logic [DW-1:0] d);
    int kd;
    string wtag;
    string rtag;
    kd = kind_of(a);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = AW'(a); bus_wdata = d;
    exp_rd = '0;
    if (rd && kd == 2) exp_rd = model[reg_of(a)];
    if (wr && kd == 0) model[reg_of(a)] = model[reg_of(a)] | d;
    if (wr && kd == 1) model[reg_of(a)] = model[reg_of(a)] & ~d;
    case (kd)
      0: wtag = wr ? "R3 set / R2 layout / R10" : "R10";
      1: wtag = wr ? "R4 clear / R2 layout / R10" : "R10";
      2: wtag = wr ? "R5 read alias write ignored" : "R10";
      default: wtag = wr ? "R8 outside write ignored" : "R10";
    endcase
    if (!rd) rtag = "R9 idle rdata zero";
    else if (kd == 2) rtag = "R6 read value";
    else if (kd == 3) rtag = "R8 outside read zero";
    else rtag = "R7 set/clear alias read zero";
    @(posedge clk);
    #1;
    compare_all(wtag, rtag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < NR; k++) model[k] = '0;
    exp_rd = '0;
    #1;
    compare_all("R1 reset ctrl", "R1 reset rdata");
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NR; k++) model[k] = '0;
    exp_rd = '0;
    repeat (3) @(posedge clk);
    do_reset();

    // R3 set bits accumulate, R4 clear bits, R2 each register's aliases
    step(1, 0, BA + 0, 16'h00F0);
    step(1, 0, BA + 0, 16'h0F00);
    step(1, 0, BA + 1, 16'h00C0);
    step(1, 0, BA + 1, 16'h0000);
    step(1, 0, BA + 0, 16'h0000);
    // R6 read right after write sees new value
    step(0, 1, BA + 2, 16'h0000);
    // R5 write to read alias ignored, then read back
    step(1, 0, BA + 2, 16'hFFFF);
    step(0, 1, BA + 2, 16'h0000);
    // R7 set/clear alias reads return zero
    step(0, 1, BA + 0, 16'h0000);
    step(0, 1, BA + 1, 16'h0000);
    // R2/R10 highest register lands in top slice
    step(1, 0, BA + 9, 16'hA5A5);
    step(1, 0, BA + 10, 16'h0005);
    step(0, 1, BA + 11, 16'h0000);
    step(1, 0, BA + 3, 16'h1234);
    step(1, 0, BA + 6, 16'h8001);
    step(0, 1, BA + 5, 16'h0000);
    step(0, 1, BA + 8, 16'h0000);
    // R8 outside window below and above
    step(1, 1, BA - 1, 16'hFFFF);
    step(1, 1, BA + 3*NR, 16'hFFFF);
    step(1, 1, 63, 16'hFFFF);
    step(0, 1, 0, 16'h0000);

    // mixed random traffic across the whole address space
    for (int i = 0; i < 3000; i++) begin
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           int'($urandom_range(0, 23)), DW'($urandom));
    end

    // R1 reset after activity
    step(1, 0, BA + 0, 16'hFFFF);
    do_reset();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule